// File: doc/BRIEF.md
# Dual-Format YCbCr Pixel Demultiplexer

This block accepts 4:2:2 component video in either of two input formats and turns it into aligned luma/chroma triples. In the narrow format a single byte lane carries Cb, Y, Cr and Y in turn, one byte per system clock. In the wide format one lane carries luma and a second lane carries alternating Cb and Cr, both moving at half the system clock rate. Everything runs on the single system clock. The half-rate pixel cadence is an internal enable that alternates every clock and is realigned on each horizontal sync falling edge.

A two-bit phase field tells the block which input sample after the horizontal sync falling edge is the first Cb of the line. From that sample on, it assembles one triple per chroma pair. Each chroma pair is presented twice, once with each of its two luma samples. A valid strobe marks each output, and a flag marks the first output of a line. A pixel-enable input forces the data outputs to blanking levels.

Top module: `ycc_pixel_demux`

## Requirements
- R1: While reset is asserted, out_valid and out_line_start are 0, out_y is 16, and out_cb and out_cr are 128.
- R2: Narrow mode (wide_mode=0). Let e0 be the first clock edge at which hsync is sampled low after it was sampled high on the edge before. Bytes are taken from lane_lo on every edge, and lane_hi is not used. With phase p, the byte at edge e0+1+p is Cb0, and the order then runs Cb, Y, Cr, Y repeatedly. After the Cr edge the outputs show (Y0, Cb0, Cr0). After the next edge they show Y1. Bit n of a lane maps to bit n of an output, so bit 0 is the LSB.
- R3: Wide mode (wide_mode=1). The active edges are e0, e0+2, e0+4 and so on. Luma is on lane_lo and chroma is on lane_hi. The first chroma sample (Cb0) is taken at edge e0+2(p+1), together with Y0. Cr0 and Y1 are taken at the next active edge, and after that edge the outputs show (Y0, Cb0, Cr0). After the edge that follows, they show Y1.
- R4: phase_sel is sampled at e0. Its value p selects the (p+1)-th active edge after e0 as the Cb0 sample, so 0 gives the second active edge counted from e0.
- R5: out_valid is high for exactly two consecutive cycles per chroma pair, one cycle per luma sample, and at no other time.
- R6: out_line_start is high only in the cycle of the first output of a line (the Y0 triple).
- R7: out_valid stays low from e0 until the first triple of the new line. Every new hsync falling edge ends the current line and restarts the phase count.
- R8: If pix_en is 0 at a clock edge, then after that edge out_y is 16 and out_cb and out_cr are 128. The timing of out_valid and out_line_start is not affected.
- R9: Both outputs of a chroma pair carry the same Cb and Cr values.
- R10: In narrow mode the value on lane_hi has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wide_mode | input | 1 | 0 = single interleaved lane, 1 = separate luma and chroma lanes at half rate |
| phase_sel | input | PHASE_W | Offset of the first Cb after the hsync falling edge |
| pix_en | input | 1 | 0 forces the data outputs to blanking levels |
| hsync | input | 1 | Horizontal sync; its falling edge starts a line |
| lane_lo | input | LANE_W | Interleaved bytes (narrow mode) or luma (wide mode) |
| lane_hi | input | LANE_W | Interleaved Cb/Cr (wide mode); unused in narrow mode |
| out_y | output | LANE_W | Luma sample |
| out_cb | output | LANE_W | Cb sample shared by both luma samples of a pair |
| out_cr | output | LANE_W | Cr sample shared by both luma samples of a pair |
| out_valid | output | 1 | One pulse per output luma sample |
| out_line_start | output | 1 | Marks the first output of a line |

## Verification
The bench builds the block with its default parameters: 8-bit lanes and a 2-bit phase field. At these values every one of the four phases can be reached in both formats, and the blanking levels 16 and 128 are representable. Consecutive lines are driven so that each new hsync falling edge lands on the clock where the next chroma pair would have started. One line inserts a short hsync pulse before the real edge, which shows that the phase count restarts. Random data on the unused high lane in narrow mode shows that this lane is ignored.

// File: rtl/ycc_demux_pkg.sv
package ycc_demux_pkg;
  // Position within a four-clock chroma pair, counted from the Cb sample.
  typedef enum logic [1:0] {
    SL_CB     = 2'd0,
    SL_LUMA_A = 2'd1,
    SL_CR     = 2'd2,
    SL_LUMA_B = 2'd3
  } slot_e;
endpackage

// File: rtl/ycc_line_sync.sv
module ycc_line_sync #(
  parameter int PHASE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide_mode,
  input  logic               hsync,
  input  logic [PHASE_W-1:0] phase_sel,
  output logic               hs_fall,
  output logic               px_act,
  output logic               cb0_hit
);
  localparam int CNT_W = PHASE_W + 1;

  logic             hs_q, hs_d;
  logic             pen_q, pen_d;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] rem_q, rem_d;

  always_comb begin
    hs_fall = hs_q & ~hsync;
    // every edge counts in narrow mode; in wide mode every second edge, with the fall edge itself active
    px_act  = ~wide_mode | hs_fall | pen_q;
    cb0_hit = armed_q & px_act & ~hs_fall & (rem_q == CNT_W'(1));
    hs_d    = hsync;
    pen_d   = hs_fall ? 1'b0 : ~pen_q;
    armed_d = armed_q;
    rem_d   = rem_q;
    if (hs_fall) begin
      armed_d = 1'b1;
      rem_d   = CNT_W'(phase_sel) + CNT_W'(1);
    end else if (armed_q && px_act) begin
      if (rem_q == CNT_W'(1)) armed_d = 1'b0;
      else                    rem_d   = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      pen_q   <= 1'b0;
      armed_q <= 1'b0;
      rem_q   <= '0;
    end else begin
      hs_q    <= hs_d;
      pen_q   <= pen_d;
      armed_q <= armed_d;
      rem_q   <= rem_d;
    end
  end

  // Wide mode: an active edge without a new fall is followed by an idle edge.
  assert_half_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && px_act && !hs_fall) ##1 (wide_mode && !hs_fall) |-> !px_act);

  // A nonzero phase never yields Cb0 on the first edge after the fall.
  assert_phase_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_fall && phase_sel != '0) |=> !cb0_hit);
endmodule

// File: rtl/ycc_slot_seq.sv
module ycc_slot_seq
  import ycc_demux_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hs_fall,
  input  logic  cb0_hit,
  output logic  slot_on,
  output slot_e slot_cur
);
  logic  run_q, run_d;
  slot_e slot_q, slot_d;

  always_comb begin
    slot_on  = cb0_hit | (run_q & ~hs_fall);
    slot_cur = cb0_hit ? SL_CB : slot_q;
    run_d    = hs_fall ? 1'b0 : (cb0_hit | run_q);
    slot_d   = slot_on ? slot_e'(slot_cur + 2'd1) : slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slot_q <= SL_CB;
    end else begin
      run_q  <= run_d;
      slot_q <= slot_d;
    end
  end

  // A found Cb0 starts the pair sequence on the following clock.
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cb0_hit |=> (run_q && slot_q == SL_LUMA_A));
endmodule

// File: rtl/ycc_lane_pack.sv
module ycc_lane_pack
  import ycc_demux_pkg::*;
#(
  parameter int LANE_W  = 8,
  parameter int BLANK_Y = 16,
  parameter int BLANK_C = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              pix_en,
  input  logic [LANE_W-1:0] lane_lo,
  input  logic [LANE_W-1:0] lane_hi,
  input  logic              slot_on,
  input  slot_e             slot_cur,
  input  logic              cb0_hit,
  output logic [LANE_W-1:0] out_y,
  output logic [LANE_W-1:0] out_cb,
  output logic [LANE_W-1:0] out_cr,
  output logic              out_valid,
  output logic              out_line_start
);
  localparam logic [LANE_W-1:0] BLK_Y = LANE_W'(BLANK_Y);
  localparam logic [LANE_W-1:0] BLK_C = LANE_W'(BLANK_C);

  logic [LANE_W-1:0] cb_p_q, cb_p_d, y_p_q, y_p_d, y2_p_q, y2_p_d;
  logic              ls_p_q, ls_p_d, sec_q, sec_d;
  logic [LANE_W-1:0] y_d, cb_d, cr_d;
  logic              valid_d, ls_d;
  logic              take_cb, take_y, emit_a;

  always_comb begin
    take_cb = slot_on && (slot_cur == SL_CB);
    take_y  = slot_on && (slot_cur == SL_LUMA_A) && !wide_mode;
    emit_a  = slot_on && (slot_cur == SL_CR);

    cb_p_d  = cb_p_q;
    y_p_d   = y_p_q;
    y2_p_d  = y2_p_q;
    ls_p_d  = ls_p_q;
    sec_d   = emit_a;
    y_d     = out_y;
    cb_d    = out_cb;
    cr_d    = out_cr;
    valid_d = 1'b0;
    ls_d    = 1'b0;

    if (take_cb) begin
      cb_p_d = wide_mode ? lane_hi : lane_lo;
      if (wide_mode) y_p_d = lane_lo;
      ls_p_d = cb0_hit;
    end
    if (take_y) y_p_d = lane_lo;

    if (emit_a) begin
      y_d     = y_p_q;
      cb_d    = cb_p_q;
      cr_d    = wide_mode ? lane_hi : lane_lo;
      y2_p_d  = lane_lo;
      valid_d = 1'b1;
      ls_d    = ls_p_q;
      ls_p_d  = 1'b0;
    end else if (sec_q) begin
      y_d     = wide_mode ? y2_p_q : lane_lo;
      valid_d = 1'b1;
    end

    if (!pix_en) begin
      y_d  = BLK_Y;
      cb_d = BLK_C;
      cr_d = BLK_C;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cb_p_q         <= '0;
      y_p_q          <= '0;
      y2_p_q         <= '0;
      ls_p_q         <= 1'b0;
      sec_q          <= 1'b0;
      out_y          <= BLK_Y;
      out_cb         <= BLK_C;
      out_cr         <= BLK_C;
      out_valid      <= 1'b0;
      out_line_start <= 1'b0;
    end else begin
      cb_p_q         <= cb_p_d;
      y_p_q          <= y_p_d;
      y2_p_q         <= y2_p_d;
      ls_p_q         <= ls_p_d;
      sec_q          <= sec_d;
      out_y          <= y_d;
      out_cb         <= cb_d;
      out_cr         <= cr_d;
      out_valid      <= valid_d;
      out_line_start <= ls_d;
    end
  end

  assert_pair_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |=> out_valid);

  assert_pair_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |=> !out_valid);

  assert_start_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_line_start |-> out_valid);

  assert_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pix_en) |-> (out_y == BLK_Y && out_cb == BLK_C && out_cr == BLK_C));
endmodule

// File: rtl/ycc_pixel_demux.sv
module ycc_pixel_demux
  import ycc_demux_pkg::*;
#(
  parameter int LANE_W  = 8,
  parameter int PHASE_W = 2,
  parameter int BLANK_Y = 16,
  parameter int BLANK_C = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide_mode,
  input  logic [PHASE_W-1:0] phase_sel,
  input  logic               pix_en,
  input  logic               hsync,
  input  logic [LANE_W-1:0]  lane_lo,
  input  logic [LANE_W-1:0]  lane_hi,
  output logic [LANE_W-1:0]  out_y,
  output logic [LANE_W-1:0]  out_cb,
  output logic [LANE_W-1:0]  out_cr,
  output logic               out_valid,
  output logic               out_line_start
);
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  logic       hs_fall, px_act, cb0_hit, slot_on;
  slot_e      slot_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  ycc_line_sync #(.PHASE_W(PHASE_W)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wide_mode (wide_mode),
    .hsync     (hsync),
    .phase_sel (phase_sel),
    .hs_fall   (hs_fall),
    .px_act    (px_act),
    .cb0_hit   (cb0_hit)
  );

  ycc_slot_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .hs_fall  (hs_fall),
    .cb0_hit  (cb0_hit),
    .slot_on  (slot_on),
    .slot_cur (slot_cur)
  );

  ycc_lane_pack #(.LANE_W(LANE_W), .BLANK_Y(BLANK_Y), .BLANK_C(BLANK_C)) u_pack (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .wide_mode      (wide_mode),
    .pix_en         (pix_en),
    .lane_lo        (lane_lo),
    .lane_hi        (lane_hi),
    .slot_on        (slot_on),
    .slot_cur       (slot_cur),
    .cb0_hit        (cb0_hit),
    .out_y          (out_y),
    .out_cb         (out_cb),
    .out_cr         (out_cr),
    .out_valid      (out_valid),
    .out_line_start (out_line_start)
  );

  // In wide mode the pair sequence only advances across an idle edge between two active ones.
  assert_pair_on_active_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wide_mode && slot_on && (slot_cur == SL_CB || slot_cur == SL_CR)) |-> px_act);
endmodule

// File: tb/ycc_pixel_demux_test.sv
module ycc_pixel_demux_test;
  localparam int LW = 8;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n, wide_mode, pix_en, hsync;
  logic [PW-1:0] phase_sel;
  logic [LW-1:0] lane_lo, lane_hi, out_y, out_cb, out_cr;
  logic          out_valid, out_line_start;

  always #10 clk = ~clk;

  ycc_pixel_demux #(.LANE_W(LW), .PHASE_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .phase_sel(phase_sel),
    .pix_en(pix_en), .hsync(hsync), .lane_lo(lane_lo), .lane_hi(lane_hi),
    .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr), .out_valid(out_valid),
    .out_line_start(out_line_start)
  );

  typedef struct {
    logic [LW-1:0] y;
    logic [LW-1:0] cb;
    logic [LW-1:0] cr;
    bit            ls;
    bit            second;
    string         tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per valid output.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) chk(1'b0, "R5 R7", "unexpected valid", 1, 0);
      else begin
        e = q.pop_front();
        chk(out_y == e.y, e.tag, "luma", out_y, e.y);
        chk(out_cb == e.cb, e.second ? "R9" : e.tag, "cb", out_cb, e.cb);
        chk(out_cr == e.cr, e.second ? "R9" : e.tag, "cr", out_cr, e.cr);
        chk(out_line_start == e.ls, "R6", "line_start", out_line_start, e.ls);
      end
    end
  end

  task automatic drive_line(input bit wide, input int ph, input int npairs, input bit en,
                            input bit glitch, input string tag);
    int d;
    int g;
    d = wide ? 2 * (ph + 1) : (ph + 1);
    g = 0;
    if (glitch) begin
      // short sync pulse: the count it starts must be abandoned (R7)
      @(negedge clk);
      hsync = 1'b0; wide_mode = wide; phase_sel = PW'(ph); pix_en = en;
      lane_lo = LW'($urandom); lane_hi = LW'($urandom);
      @(negedge clk);
      hsync = 1'b1; lane_lo = LW'($urandom); lane_hi = LW'($urandom);
    end
    for (int t = 0; t < d; t++) begin
      @(negedge clk);
      if (t > 0 || glitch) chk(out_valid == 1'b0, "R7", "valid before first Cb", out_valid, 0);
      hsync = (g < 3) ? 1'b0 : 1'b1; g++;
      wide_mode = wide; phase_sel = PW'(ph); pix_en = en;
      lane_lo = LW'($urandom); lane_hi = LW'($urandom);
    end
    for (int k = 0; k < npairs; k++) begin
      logic [LW-1:0] cb, cr, y0, y1;
      cb = LW'($urandom); cr = LW'($urandom); y0 = LW'($urandom); y1 = LW'($urandom);
      q.push_back('{en ? y0 : LW'(16), en ? cb : LW'(128), en ? cr : LW'(128), (k == 0), 1'b0, tag});
      q.push_back('{en ? y1 : LW'(16), en ? cb : LW'(128), en ? cr : LW'(128), 1'b0, 1'b1, tag});
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        if (k == 0 && j == 0) chk(out_valid == 1'b0, "R7", "valid before first Cb", out_valid, 0);
        hsync = (g < 3) ? 1'b0 : 1'b1; g++;
        if (wide) begin
          lane_lo = (j < 2) ? y0 : y1;
          lane_hi = (j < 2) ? cb : cr;
        end else begin
          case (j)
            0: lane_lo = cb;
            1: lane_lo = y0;
            2: lane_lo = cr;
            default: lane_lo = y1;
          endcase
          lane_hi = LW'($urandom); // R10: junk on the unused lane
        end
      end
    end
  endtask

  task automatic reset_checks();
    chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    chk(out_line_start == 1'b0, "R1", "line_start in reset", out_line_start, 0);
    chk(out_y == LW'(16), "R1", "luma in reset", out_y, 16);
    chk(out_cb == LW'(128) && out_cr == LW'(128), "R1", "chroma in reset", out_cb, 128);
  endtask

  initial begin
    rst_n = 1'b0; hsync = 1'b1; wide_mode = 1'b0; pix_en = 1'b1;
    phase_sel = '0; lane_lo = '0; lane_hi = '0;
    repeat (3) @(negedge clk);
    reset_checks();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    drive_line(1'b0, 0, 3, 1'b1, 1'b0, "R2 R10");
    drive_line(1'b0, 1, 2, 1'b1, 1'b0, "R4");
    drive_line(1'b0, 2, 2, 1'b1, 1'b0, "R4");
    drive_line(1'b0, 3, 2, 1'b1, 1'b0, "R4");
    drive_line(1'b1, 0, 3, 1'b1, 1'b0, "R3");
    drive_line(1'b1, 1, 2, 1'b1, 1'b0, "R3 R4");
    drive_line(1'b1, 2, 2, 1'b1, 1'b0, "R3 R4");
    drive_line(1'b1, 3, 2, 1'b1, 1'b0, "R3 R4");
    drive_line(1'b0, 2, 2, 1'b0, 1'b0, "R8");
    drive_line(1'b1, 3, 2, 1'b0, 1'b0, "R8");
    drive_line(1'b0, 0, 3, 1'b1, 1'b1, "R7");
    drive_line(1'b1, 2, 2, 1'b1, 1'b0, "R3");

    @(negedge clk);
    hsync = 1'b1; lane_lo = LW'($urandom); lane_hi = LW'($urandom);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    reset_checks();
    chk(q.size() == 0, "R5", "outputs still pending", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule